// File: doc/BRIEF.md
# Two-Dimensional Strided Transfer Address Walker

This block turns one transfer descriptor into a stream of bus-beat addresses. A descriptor holds a start byte address, a row length in bytes, a row count and a row pitch (stride). The walker produces the beats of each row at bus-width steps. At the end of a row it jumps the row origin forward by the stride, so the stride covers the row plus any gap to the next row. A row count of one gives an ordinary linear transfer.

A downstream data mover takes beats through a valid/accept handshake. The walker marks the last beat of every row and the last beat of the whole transfer. When a non-repeating transfer is finished, it gives a one-cycle completion pulse. With the repeat flag set, the walker starts the same pattern again from the start address after the final beat and keeps going until reset.

Both lengths are programmed as value minus one. A descriptor is checked for bus-width alignment when it is offered. A misaligned descriptor is refused with an error pulse and produces no beats. Descriptors are taken only while the walker is idle.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, `idle` is 1 and `beat_valid`, `done` and `desc_err` are all 0.
- R2: A descriptor is taken when `desc_valid` is high in a cycle where `idle` is 1. While a transfer is running, `desc_valid` is ignored: the beat sequence continues unchanged and no error is raised.
- R3: A descriptor is refused if any of the following holds: the start address is not a multiple of BEAT_BYTES, the row length (`desc_xlen_m1`+1) is not a multiple of BEAT_BYTES, or the stride is not a multiple of BEAT_BYTES. On refusal, `desc_err` is high for one cycle in the cycle after the offer, `idle` stays 1 and no beat is produced. Every address the walker presents stays aligned.
- R4: The first beat appears in the cycle after the descriptor is taken, at the start address. While `beat_valid` is high and `beat_accept` is low, `beat_valid` and `beat_addr` hold.
- R5: Within a row, each accepted beat advances the address by BEAT_BYTES. A row holds (`desc_xlen_m1`+1)/BEAT_BYTES beats, and `row_last` is high on exactly the last of them.
- R6: Each new row starts at the previous row's start plus `desc_stride`, modulo 2^ADDR_W. There are `desc_ylen_m1`+1 rows, so a value of 0 gives a single row.
- R7: `xfer_last` is high on exactly the final beat of the final row, together with `row_last`.
- R8: Without the repeat flag, the cycle after the final beat is accepted shows `done` high for one cycle, `beat_valid` low and `idle` high.
- R9: With the repeat flag set, the beat after the final one is again at the start address, with row and beat counts reloaded. `done` never rises.
- R10: The row length field is LEN_W bits wide. An all-ones value, which gives a row of 2^LEN_W bytes, is handled like any other length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_valid | input | 1 | Descriptor offered this cycle |
| desc_addr | input | ADDR_W | Start byte address |
| desc_xlen_m1 | input | LEN_W | Row length in bytes minus one |
| desc_ylen_m1 | input | LEN_W | Row count minus one |
| desc_stride | input | LEN_W | Byte distance between row starts |
| desc_cyclic | input | 1 | Repeat the pattern after the final beat |
| beat_accept | input | 1 | Consumer takes the presented beat |
| idle | output | 1 | Walker can take a descriptor |
| beat_valid | output | 1 | A beat address is presented |
| beat_addr | output | ADDR_W | Byte address of the presented beat |
| row_last | output | 1 | Presented beat ends its row |
| xfer_last | output | 1 | Presented beat ends the transfer |
| done | output | 1 | One-cycle pulse after a non-repeating transfer ends |
| desc_err | output | 1 | One-cycle pulse for a refused descriptor |

## Verification
If the beat counter is off by one, a row comes out one beat too long or too short. The error shows up on the first row: `row_last` lands on the wrong beat, and the next address is off by BEAT_BYTES or by the stride gap. A wrong row-origin register or a stale stride first shows on the first beat of the second row, so every test pattern with more than one row checks that boundary. A wrong reload copy only shows on the first beat after a repeat wrap or at the second row of a new descriptor, so repeating transfers are run through at least two passes. Stalls on `beat_accept` are inserted at random, which exposes any address that moves without an accepted beat on the very next cycle.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_e;

endpackage

// File: rtl/dma2d_desc_check.sv
module dma2d_desc_check #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int BEAT_BYTES = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  xlen_m1,
  input  logic [LEN_W-1:0]  stride,
  output logic              ok
);

  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(BEAT_BYTES - 1);
  localparam logic [LEN_W-1:0]  L_MASK = LEN_W'(BEAT_BYTES - 1);

  generate
    if (BEAT_BYTES == 1) begin : g_byte_bus
      assign ok = 1'b1;
    end else begin : g_wide_bus
      // length is minus-one coded: an aligned length has all mask bits set
      assign ok = ((addr & A_MASK) == '0) &&
                  ((xlen_m1 & L_MASK) == L_MASK) &&
                  ((stride & L_MASK) == '0);
    end
  endgenerate

endmodule

// File: rtl/dma2d_count_dn.sv
module dma2d_count_dn #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         cfg_we,
  input  logic [W-1:0] cfg_val,
  input  logic         restart,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         zero
);

  logic [W-1:0] reload_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '0;
      cnt_q    <= '0;
    end else if (cfg_we) begin
      reload_q <= cfg_val;
      cnt_q    <= cfg_val;
    end else if (restart) begin
      cnt_q <= reload_q;
    end else if (dec) begin
      cnt_q <= cnt_q - W'(1);
    end
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

  // R5: a plain decrement moves the count by exactly one
  p_dec_one_r5: assert property (@(posedge clk) disable iff (rst)
    (dec && !cfg_we && !restart) |=> (cnt_q == $past(cnt_q) - W'(1)));

  // R5: the controller never decrements through zero
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (rst)
    (dec && !cfg_we && !restart) |-> (cnt_q != '0));

endmodule

// File: rtl/dma2d_addr_walk.sv
module dma2d_addr_walk #(
  parameter int ADDR_W     = 32,
  parameter int STRIDE_W   = 12,
  parameter int BEAT_BYTES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_we,
  input  logic [ADDR_W-1:0]   cfg_start,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic                restart,
  input  logic                next_row,
  input  logic                next_beat,
  output logic [ADDR_W-1:0]   addr
);

  localparam logic [ADDR_W-1:0] STEP   = ADDR_W'(BEAT_BYTES);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(BEAT_BYTES - 1);

  logic [ADDR_W-1:0] start_q;
  logic [ADDR_W-1:0] stride_q;
  logic [ADDR_W-1:0] row_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] row_nxt;

  assign row_nxt = row_q + stride_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q  <= '0;
      stride_q <= '0;
      row_q    <= '0;
      addr_q   <= '0;
    end else if (cfg_we) begin
      start_q  <= cfg_start;
      stride_q <= ADDR_W'(cfg_stride);
      row_q    <= cfg_start;
      addr_q   <= cfg_start;
    end else if (restart) begin
      row_q  <= start_q;
      addr_q <= start_q;
    end else if (next_row) begin
      row_q  <= row_nxt;
      addr_q <= row_nxt;
    end else if (next_beat) begin
      addr_q <= addr_q + STEP;
    end
  end

  assign addr = addr_q;

  // R5: a beat step inside a row moves the address by one bus width
  p_beat_step_r5: assert property (@(posedge clk) disable iff (rst)
    (next_beat && !cfg_we && !restart && !next_row) |=> (addr_q == $past(addr_q) + STEP));

  // R3: only aligned descriptors reach here, so every address stays aligned
  p_addr_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    (addr_q & A_MASK) == '0);

  // R9: a restart puts the beat address back on the row origin
  p_restart_origin_r9: assert property (@(posedge clk) disable iff (rst)
    (restart && !cfg_we) |=> (addr_q == row_q));

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int BEAT_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              desc_valid,
  input  logic [ADDR_W-1:0] desc_addr,
  input  logic [LEN_W-1:0]  desc_xlen_m1,
  input  logic [LEN_W-1:0]  desc_ylen_m1,
  input  logic [LEN_W-1:0]  desc_stride,
  input  logic              desc_cyclic,
  input  logic              beat_accept,
  output logic              idle,
  output logic              beat_valid,
  output logic [ADDR_W-1:0] beat_addr,
  output logic              row_last,
  output logic              xfer_last,
  output logic              done,
  output logic              desc_err
);

  import dma2d_pkg::*;

  localparam int ALIGN_W = $clog2(BEAT_BYTES);
  localparam int BEAT_CW = (LEN_W > ALIGN_W) ? (LEN_W - ALIGN_W) : 1;

  walk_e state_q;
  logic  cyc_q;
  logic  done_q;
  logic  err_q;

  logic  chk_ok;
  logic  load_ok;
  logic  acc;
  logic  x_zero;
  logic  y_zero;
  logic  row_end;
  logic  xfer_end;
  logic [BEAT_CW-1:0] x_cnt;
  logic [LEN_W-1:0]   y_cnt;
  logic [ADDR_W-1:0]  walk_addr;

  dma2d_desc_check #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)
  ) u_check (
    .addr(desc_addr), .xlen_m1(desc_xlen_m1), .stride(desc_stride), .ok(chk_ok)
  );

  assign load_ok  = desc_valid && (state_q == WALK_IDLE) && chk_ok;
  assign acc      = (state_q == WALK_RUN) && beat_accept;
  assign row_end  = acc && x_zero;
  assign xfer_end = row_end && y_zero;

  // beats left in the current row, minus one
  dma2d_count_dn #(.W(BEAT_CW)) u_xcnt (
    .clk(clk), .rst(rst),
    .cfg_we(load_ok), .cfg_val(BEAT_CW'(desc_xlen_m1 >> ALIGN_W)),
    .restart(row_end), .dec(acc && !x_zero),
    .cnt(x_cnt), .zero(x_zero)
  );

  // rows left in the transfer, minus one
  dma2d_count_dn #(.W(LEN_W)) u_ycnt (
    .clk(clk), .rst(rst),
    .cfg_we(load_ok), .cfg_val(desc_ylen_m1),
    .restart(xfer_end), .dec(row_end && !y_zero),
    .cnt(y_cnt), .zero(y_zero)
  );

  dma2d_addr_walk #(
    .ADDR_W(ADDR_W), .STRIDE_W(LEN_W), .BEAT_BYTES(BEAT_BYTES)
  ) u_walk (
    .clk(clk), .rst(rst),
    .cfg_we(load_ok), .cfg_start(desc_addr), .cfg_stride(desc_stride),
    .restart(xfer_end), .next_row(row_end && !y_zero), .next_beat(acc && !x_zero),
    .addr(walk_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WALK_IDLE;
      cyc_q   <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= xfer_end && !cyc_q;
      err_q  <= desc_valid && (state_q == WALK_IDLE) && !chk_ok;
      if (load_ok) begin
        state_q <= WALK_RUN;
        cyc_q   <= desc_cyclic;
      end else if (xfer_end && !cyc_q) begin
        state_q <= WALK_IDLE;
      end
    end
  end

  assign idle       = (state_q == WALK_IDLE);
  assign beat_valid = (state_q == WALK_RUN);
  assign beat_addr  = walk_addr;
  assign row_last   = beat_valid && x_zero;
  assign xfer_last  = beat_valid && x_zero && y_zero;
  assign done       = done_q;
  assign desc_err   = err_q;

  // R4: a stalled beat keeps its address and stays valid
  p_hold_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_accept) |=> (beat_valid && $stable(beat_addr)));

  // R2: an offer during a running transfer neither stops it nor raises an error
  p_busy_ignores_r2: assert property (@(posedge clk) disable iff (rst)
    (!idle && desc_valid && !(acc && xfer_last)) |=> (!idle && !desc_err));

  // R3: a refusal leaves no beat behind
  p_err_no_beat_r3: assert property (@(posedge clk) disable iff (rst)
    desc_err |-> (idle && !beat_valid));

  // R8: completion is a single-cycle pulse seen while idle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (idle && !beat_valid));

  // R9: a repeating transfer keeps presenting beats after its final one
  p_cyclic_wrap_r9: assert property (@(posedge clk) disable iff (rst)
    (acc && xfer_last && cyc_q) |=> (beat_valid && !done));

endmodule

// File: tb/sim_dma2d_addr_gen.sv
module sim_dma2d_addr_gen;

  localparam int AW = 32;
  localparam int LW = 12;
  localparam int BB = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          desc_valid;
  logic [AW-1:0] desc_addr;
  logic [LW-1:0] desc_xlen_m1;
  logic [LW-1:0] desc_ylen_m1;
  logic [LW-1:0] desc_stride;
  logic          desc_cyclic;
  logic          beat_accept;
  logic          idle, beat_valid, row_last, xfer_last, done, desc_err;
  logic [AW-1:0] beat_addr;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  dma2d_addr_gen #(.ADDR_W(AW), .LEN_W(LW), .BEAT_BYTES(BB)) u0 (
    .clk(clk), .rst(rst), .desc_valid(desc_valid), .desc_addr(desc_addr),
    .desc_xlen_m1(desc_xlen_m1), .desc_ylen_m1(desc_ylen_m1),
    .desc_stride(desc_stride), .desc_cyclic(desc_cyclic),
    .beat_accept(beat_accept), .idle(idle), .beat_valid(beat_valid),
    .beat_addr(beat_addr), .row_last(row_last), .xfer_last(xfer_last),
    .done(done), .desc_err(desc_err)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] start, input int stride,
                                              input int row, input int beat);
    return start + AW'(row * stride) + AW'(beat * BB);
  endfunction

  task automatic do_reset();
    rst = 1'b1; desc_valid = 1'b0; beat_accept = 1'b0; desc_cyclic = 1'b0;
    desc_addr = '0; desc_xlen_m1 = '0; desc_ylen_m1 = '0; desc_stride = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", {60'd0, idle, beat_valid, done, desc_err}, 64'b1000);
  endtask

  task automatic run_desc(input logic [AW-1:0] start, input int beats, input int rows,
                          input int stride, input bit cyc, input int passes,
                          input int acc_pct, input bit inject);
    @(negedge clk);
    chk("R2", {63'd0, idle}, 64'd1);
    desc_addr = start; desc_xlen_m1 = LW'(beats * BB - 1); desc_ylen_m1 = LW'(rows - 1);
    desc_stride = LW'(stride); desc_cyclic = cyc; desc_valid = 1'b1;
    @(negedge clk);
    desc_valid = 1'b0;
    for (int p = 0; p < passes; p++) begin
      for (int r = 0; r < rows; r++) begin
        for (int b = 0; b < beats; b++) begin
          bit first = 1'b1;
          bit go;
          string tag;
          logic [AW-1:0] ea;
          ea = exp_addr(start, stride, r, b);
          forever begin
            if (!first) tag = "R4";
            else if (p > 0 && r == 0 && b == 0) tag = "R9";
            else if (r > 0 && b == 0) tag = "R6";
            else if (b == beats - 1) tag = "R7";
            else tag = "R5";
            // valid, row_last, xfer_last, done, err, address
            chk(tag, {27'd0, beat_valid, row_last, xfer_last, done, desc_err, beat_addr},
                {27'd0, 1'b1, (b == beats - 1), (b == beats - 1 && r == rows - 1),
                 1'b0, 1'b0, ea});
            if (inject && first && p == 0 && r == 0 && b == 0) begin
              desc_valid = 1'b1; desc_addr = start + 32'h100; desc_xlen_m1 = LW'(3);
              desc_ylen_m1 = '0; desc_stride = '0; go = 1'b0;  // R2: offer while busy
            end else begin
              go = (($urandom % 100) < acc_pct);
            end
            beat_accept = go;
            @(negedge clk);
            desc_valid = 1'b0;
            beat_accept = 1'b0;
            first = 1'b0;
            if (go) break;
          end
        end
      end
    end
    if (!cyc) begin
      chk("R8", {61'd0, done, beat_valid, idle}, 64'b101);
      @(negedge clk);
      chk("R8", {63'd0, done}, 64'd0);
    end else begin
      chk("R9", {31'd0, beat_valid, done, beat_addr}, {31'd0, 1'b1, 1'b0, start});
      do_reset();
    end
  endtask

  task automatic bad_desc(input logic [AW-1:0] a, input logic [LW-1:0] xm1,
                          input logic [LW-1:0] ym1, input logic [LW-1:0] st);
    @(negedge clk);
    desc_addr = a; desc_xlen_m1 = xm1; desc_ylen_m1 = ym1; desc_stride = st;
    desc_cyclic = 1'b0; desc_valid = 1'b1;
    @(negedge clk);
    desc_valid = 1'b0;
    chk("R3", {61'd0, desc_err, beat_valid, idle}, 64'b101);
    @(negedge clk);
    chk("R3", {61'd0, desc_err, beat_valid, idle}, 64'b001);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'd20240611);
    do_reset();
    // directed corner cases
    run_desc(32'h0000_1000, 1, 1, 0, 1'b0, 1, 100, 1'b0);      // single beat, single row
    run_desc(32'h0000_2000, 5, 1, 0, 1'b0, 1, 60, 1'b0);       // one-dimensional
    run_desc(32'h0000_3000, 3, 4, 20, 1'b0, 1, 70, 1'b0);      // row gap via stride
    run_desc(32'h0000_4000, 2, 3, 8, 1'b0, 1, 100, 1'b0);      // contiguous rows
    run_desc(32'hFFFF_FFF8, 2, 2, 8, 1'b0, 1, 80, 1'b0);       // address wrap R6
    run_desc(32'h0000_5000, 2, 2, 12, 1'b0, 1, 50, 1'b1);      // offer while busy R2
    bad_desc(32'h0000_6001, LW'(7), '0, '0);                   // misaligned address
    bad_desc(32'h0000_6000, LW'(6), '0, '0);                   // length not a multiple
    bad_desc(32'h0000_6000, LW'(7), LW'(1), LW'(10));          // misaligned stride
    run_desc(32'h0000_7000, 3, 2, 16, 1'b1, 2, 75, 1'b0);      // repeating R9
    run_desc(32'h0000_8000, 1, 1, 0, 1'b1, 3, 100, 1'b0);      // repeating, one beat
    run_desc(32'h0001_0000, 1 << (LW - 2), 2, 4092, 1'b0, 1, 100, 1'b0); // R10 max length
    // constrained random descriptors
    for (int i = 0; i < 24; i++) begin
      int beats, rows, gap, pct;
      logic [AW-1:0] a;
      beats = 1 + int'($urandom % 6);
      rows  = 1 + int'($urandom % 4);
      gap   = int'($urandom % 4);
      pct   = 40 + int'($urandom % 61);
      a     = $urandom & ~32'h3;
      run_desc(a, beats, rows, (beats + gap) * BB, 1'b0, 1, pct, (i % 5) == 0);
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule